// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block sits beside a DDR3 memory controller and decides when an auto-refresh command goes out. A free-running interval counter adds one owed refresh each time it expires. The expiry period is the nominal refresh interval when the case temperature is in the normal range, and half of it when the hot flag reports a case above 85 °C. Owed refreshes are kept in a small saturating count, so up to eight can be postponed while the controller is busy. Once eight are owed, an urgency flag asks the controller to stop and drain.

A refresh is issued in the first cycle in which a refresh is owed, the controller reports every bank idle, and no earlier refresh is still recovering. From that cycle the block raises a blocking flag for the whole refresh recovery window, during which the controller must send nothing. The block also works out the two mode-register bits for self-refresh temperature range that the controller writes before self-refresh entry. In the hot range this is either the manual extended-range code or the auto self-refresh code, chosen by a parameter. It also tells the controller when self-refresh entry is permitted.

With the default parameters (1.25 ns clock), the normal interval is 6240 cycles, the hot interval is 3120 cycles and the recovery window is 208 cycles.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ref_req_o, ref_urgent_o, ref_fire_o, busy_o and sr_ok_o are 0 and sr_mode_o is 2'b00.
- R2: With hot_i low at every reload, one owed refresh is added every NORM_INTERVAL cycles. The first is added NORM_INTERVAL clock edges after reset is released.
- R3: When hot_i is high at a reload, the next interval lasts NORM_INTERVAL/2 cycles.
- R4: hot_i is sampled only at interval reloads. A change in the middle of an interval does not shorten or lengthen that interval.
- R5: ref_fire_o is high for one cycle only when a refresh is owed, banks_idle_i is high and no recovery is in progress. Each fire removes one owed refresh.
- R6: busy_o is high from the fire cycle for exactly RFC_CYCLES consecutive cycles. Two fires are therefore at least RFC_CYCLES cycles apart.
- R7: The owed count saturates at MAX_PENDING. An expiry that would exceed it is dropped, unless a fire in the same cycle frees a slot. ref_urgent_o is high exactly when the count equals MAX_PENDING.
- R8: ref_req_o is high exactly when at least one refresh is owed.
- R9: sr_mode_o holds the self-refresh range code one cycle after hot_i is sampled. The code is 2'b00 when not hot. When hot it is 2'b10 (bit1 = 1, bit0 = 0: manual extended range) for AUTO_SR = 0, and 2'b01 (bit0 = 1: auto self-refresh) for AUTO_SR = 1.
- R10: While sr_req_i is high, sr_mode_o does not change.
- R11: sr_ok_o equals sr_req_i and banks_idle_i and not busy_o. A refresh fire in the same cycle wins, so sr_ok_o is 0 whenever ref_fire_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_i | input | 1 | Case temperature above 85 °C |
| banks_idle_i | input | 1 | All banks precharged and idle |
| sr_req_i | input | 1 | Controller wants to enter self-refresh |
| ref_req_o | output | 1 | At least one refresh is owed |
| ref_urgent_o | output | 1 | Owed count is at its maximum |
| ref_fire_o | output | 1 | Issue an auto-refresh this cycle |
| busy_o | output | 1 | Command bus blocked for refresh recovery |
| sr_ok_o | output | 1 | Self-refresh entry permitted this cycle |
| sr_mode_o | output | 2 | Self-refresh range bits: bit0 auto, bit1 extended |

## Verification
Two collisions matter here. An interval expiry can land in the same cycle as a fire, and a self-refresh request can be live in the cycle a refresh becomes owed. The bench holds sr_req_i high across the cycle in which the first refresh becomes owed. It then checks that the fire goes out, that sr_ok_o stays low for the full recovery window, and that sr_ok_o returns on the first cycle after it. In a separate run, the owed count is driven into saturation and then drained. The scoreboard compares every fire cycle against a list worked out from the interval and recovery lengths, including the expiries that fall during the drain.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   // Self-refresh range codes; bit0 = auto self-refresh, bit1 = extended range
   typedef enum logic [1:0] {
      SR_NORMAL = 2'b00,
      SR_AUTO   = 2'b01,
      SR_EXT    = 2'b10
   } sr_mode_e;
endpackage

// File: rtl/rfs_interval.sv
module rfs_interval #(
   parameter int NORM_INTERVAL = 6240
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_i,
   output logic tick_o
);
   localparam int HOT_INTERVAL = NORM_INTERVAL / 2;
   localparam int CW           = $clog2(NORM_INTERVAL);
   localparam logic [CW-1:0] NORM_LD = CW'(NORM_INTERVAL - 1);
   localparam logic [CW-1:0] HOT_LD  = CW'(HOT_INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   assign tick_o = (cnt_q == '0);

   // temperature is looked at only when a new interval is loaded
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= NORM_LD;
      else if (tick_o) cnt_q <= hot_i ? HOT_LD : NORM_LD;
      else             cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/rfs_pending.sv
module rfs_pending #(
   parameter int MAX_PENDING = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic take_i,
   output logic req_o,
   output logic urgent_o
);
   localparam int PW = $clog2(MAX_PENDING + 1);
   localparam logic [PW-1:0] FULL_V = PW'(MAX_PENDING);

   logic [PW-1:0] pend_q;
   logic          full, inc;

   assign full     = (pend_q == FULL_V);
   assign inc      = tick_i && (!full || take_i);
   assign req_o    = (pend_q != '0);
   assign urgent_o = full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else begin
         unique case ({inc, take_i})
            2'b10:   pend_q <= pend_q + 1'b1;
            2'b01:   pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
      end
   end
endmodule

// File: rtl/rfs_recovery.sv
module rfs_recovery #(
   parameter int RFC_CYCLES = 208
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic hold_o
);
   localparam int RW = $clog2(RFC_CYCLES);
   localparam logic [RW-1:0] RFC_LD = RW'(RFC_CYCLES - 1);

   logic [RW-1:0] rcnt_q;

   // the fire cycle itself is the first blocked cycle; this covers the rest
   assign hold_o = (rcnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rcnt_q <= '0;
      else if (start_i) rcnt_q <= RFC_LD;
      else if (hold_o)  rcnt_q <= rcnt_q - 1'b1;
   end
endmodule

// File: rtl/rfs_sr_mode.sv
module rfs_sr_mode
   import rfs_pkg::*;
#(
   parameter bit AUTO_SR = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hot_i,
   input  logic       sr_req_i,
   output logic [1:0] mode_o
);
   sr_mode_e hot_code, next_code, mode_q;

   generate
      if (AUTO_SR) begin : g_auto
         assign hot_code = SR_AUTO;
      end else begin : g_ext
         assign hot_code = SR_EXT;
      end
   endgenerate

   assign next_code = hot_i ? hot_code : SR_NORMAL;
   assign mode_o    = mode_q;

   // frozen while the controller is heading into self-refresh
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= SR_NORMAL;
      else if (!sr_req_i) mode_q <= next_code;
   end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
   parameter int NORM_INTERVAL = 6240,
   parameter int RFC_CYCLES    = 208,
   parameter int MAX_PENDING   = 8,
   parameter bit AUTO_SR       = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hot_i,
   input  logic       banks_idle_i,
   input  logic       sr_req_i,
   output logic       ref_req_o,
   output logic       ref_urgent_o,
   output logic       ref_fire_o,
   output logic       busy_o,
   output logic       sr_ok_o,
   output logic [1:0] sr_mode_o
);
   generate
      if (NORM_INTERVAL < 4 || (NORM_INTERVAL % 2) != 0) begin : g_bad_interval
         $error("NORM_INTERVAL must be even and at least 4");
      end
      if (RFC_CYCLES < 2) begin : g_bad_rfc
         $error("RFC_CYCLES must be at least 2");
      end
      if (MAX_PENDING < 1) begin : g_bad_pend
         $error("MAX_PENDING must be at least 1");
      end
   endgenerate

   logic tick, hold;

   rfs_interval #(.NORM_INTERVAL(NORM_INTERVAL)) u_interval (
      .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .tick_o(tick)
   );

   rfs_pending #(.MAX_PENDING(MAX_PENDING)) u_pending (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .take_i(ref_fire_o),
      .req_o(ref_req_o), .urgent_o(ref_urgent_o)
   );

   rfs_recovery #(.RFC_CYCLES(RFC_CYCLES)) u_recovery (
      .clk(clk), .rst_n(rst_n), .start_i(ref_fire_o), .hold_o(hold)
   );

   rfs_sr_mode #(.AUTO_SR(AUTO_SR)) u_sr_mode (
      .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .sr_req_i(sr_req_i),
      .mode_o(sr_mode_o)
   );

   assign ref_fire_o = ref_req_o && banks_idle_i && !hold;
   assign busy_o     = ref_fire_o || hold;
   assign sr_ok_o    = sr_req_i && banks_idle_i && !busy_o;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
   parameter int RFC = 208
) (
   input logic       clk,
   input logic       rst_n,
   input logic       banks_idle_i,
   input logic       sr_req_i,
   input logic       ref_req_o,
   input logic       ref_urgent_o,
   input logic       ref_fire_o,
   input logic       busy_o,
   input logic       sr_ok_o,
   input logic [1:0] sr_mode_o
);
   localparam int GW = $clog2(RFC + 1);
   localparam logic [GW-1:0] GAP_FULL = GW'(RFC);

   // cycles since the last fire, saturating at the recovery length
   logic [GW-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap_q <= GAP_FULL;
      else if (ref_fire_o)       gap_q <= GW'(1);
      else if (gap_q != GAP_FULL) gap_q <= gap_q + 1'b1;
   end

   a_r5_fire_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ref_fire_o |-> (banks_idle_i && ref_req_o));

   a_r6_rfc_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ref_fire_o |-> (gap_q == GAP_FULL));

   a_r6_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ref_fire_o |=> busy_o);

   a_r7_urgent_owed: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent_o |-> ref_req_o);

   a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      sr_req_i |=> $stable(sr_mode_o));

   a_r11_fire_wins: assert property (@(posedge clk) disable iff (!rst_n)
      !(ref_fire_o && sr_ok_o));
endmodule

bind refresh_sched rfs_checker #(.RFC(RFC_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .banks_idle_i(banks_idle_i), .sr_req_i(sr_req_i),
   .ref_req_o(ref_req_o), .ref_urgent_o(ref_urgent_o), .ref_fire_o(ref_fire_o),
   .busy_o(busy_o), .sr_ok_o(sr_ok_o), .sr_mode_o(sr_mode_o)
);

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
   localparam int NORM = 40;
   localparam int RFC  = 10;
   localparam int MAXP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hot = 1'b0, idle = 1'b0, srq = 1'b0;
   logic req, urg, fire, busy, srok;
   logic [1:0] srm;
   logic a_req, a_urg, a_fire, a_busy, a_srok;
   logic [1:0] a_srm;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int exp_q[$];

   always #10 clk = ~clk;

   refresh_sched #(.NORM_INTERVAL(NORM), .RFC_CYCLES(RFC), .MAX_PENDING(MAXP),
                   .AUTO_SR(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .hot_i(hot), .banks_idle_i(idle), .sr_req_i(srq),
      .ref_req_o(req), .ref_urgent_o(urg), .ref_fire_o(fire), .busy_o(busy),
      .sr_ok_o(srok), .sr_mode_o(srm));

   refresh_sched #(.NORM_INTERVAL(NORM), .RFC_CYCLES(RFC), .MAX_PENDING(MAXP),
                   .AUTO_SR(1'b1)) dut_a (
      .clk(clk), .rst_n(rst_n), .hot_i(hot), .banks_idle_i(idle), .sr_req_i(srq),
      .ref_req_o(a_req), .ref_urgent_o(a_urg), .ref_fire_o(a_fire), .busy_o(a_busy),
      .sr_ok_o(a_srok), .sr_mode_o(a_srm));

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   // scoreboard monitor: every observed fire must match the next expected cycle
   always @(negedge clk) begin
      if (rst_n && fire && !done) begin
         if (exp_q.size() == 0) chk("R5 unexpected fire", cyc, -1);
         else chk("R5/R6 fire cycle", cyc, exp_q.pop_front());
      end
   end

   task automatic push(input int c);
      exp_q.push_back(c);
   endtask

   task automatic at_neg(input int n);
      do @(negedge clk); while (cyc < n);
   endtask

   task automatic drive_at(input int n);
      do begin @(posedge clk); #2; end while (cyc < n);
   endtask

   task automatic restart(input logic h, input logic i, input logic s);
      @(posedge clk); #2;
      rst_n = 1'b0; hot = h; idle = i; srq = s;
      exp_q.delete();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   task automatic drained(input string tag);
      chk(tag, exp_q.size(), 0);
   endtask

   initial begin
      // R1: reset state
      restart(1'b0, 1'b1, 1'b0);
      at_neg(1);
      chk("R1 req", req, 0);
      chk("R1 urgent", urg, 0);
      chk("R1 fire", fire, 0);
      chk("R1 busy", busy, 0);
      chk("R1 sr_ok", srok, 0);
      chk("R1 sr_mode", srm, 0);

      // R2 R5 R6 R8: normal interval, always idle
      push(40); push(80); push(120); push(160);
      at_neg(39);  chk("R8 req before first expiry", req, 0);
      at_neg(40);  chk("R6 busy in fire cycle", busy, 1);
      chk("R8 req while owed", req, 1);
      at_neg(41);  chk("R8 req after fire", req, 0);
      at_neg(49);  chk("R6 busy last blocked cycle", busy, 1);
      at_neg(50);  chk("R6 busy released", busy, 0);
      at_neg(165); drained("R2 all normal fires seen");

      // R3 R4 R9: hot flag changes mid-interval
      restart(1'b0, 1'b1, 1'b0);
      push(40); push(80); push(100); push(120); push(140); push(180);
      drive_at(50); hot = 1'b1;
      at_neg(50);  chk("R9 mode before capture", srm, 0);
      at_neg(51);  chk("R9 manual extended code", srm, 2);
      chk("R9 auto code", a_srm, 1);
      drive_at(125); hot = 1'b0;
      at_neg(126); chk("R9 normal code", srm, 0);
      at_neg(185); drained("R3 R4 hot interval fires seen");

      // R7 R5: postpone to saturation, then drain
      restart(1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 10; k++) push(405 + 10 * k);
      at_neg(40);  chk("R8 req with bank busy", req, 1);
      chk("R7 not urgent at one", urg, 0);
      at_neg(319); chk("R7 not urgent at seven", urg, 0);
      at_neg(320); chk("R7 urgent at eight", urg, 1);
      at_neg(404); chk("R7 still urgent after extra expiries", urg, 1);
      chk("R5 no fire while not idle", fire, 0);
      drive_at(405); idle = 1'b1;
      at_neg(406); chk("R7 urgent cleared by one fire", urg, 0);
      chk("R6 busy after fire", busy, 1);
      at_neg(496); chk("R7 drained count", req, 0);
      at_neg(500); drained("R7 saturated drain fires seen");

      // R11 R10: self-refresh request against a refresh
      restart(1'b0, 1'b1, 1'b0);
      push(40); push(80);
      drive_at(30); srq = 1'b1;
      at_neg(30);  chk("R11 sr_ok when idle", srok, 1);
      at_neg(40);  chk("R11 fire wins", srok, 0);
      at_neg(45);  chk("R11 blocked in recovery", srok, 0);
      at_neg(50);  chk("R11 sr_ok after recovery", srok, 1);
      drive_at(52); hot = 1'b1;
      at_neg(54);  chk("R10 mode frozen", srm, 0);
      drive_at(56); srq = 1'b0;
      at_neg(57);  chk("R10 mode updates after release", srm, 2);
      drive_at(60); srq = 1'b1; idle = 1'b0;
      at_neg(60);  chk("R11 no sr_ok when not idle", srok, 0);
      drive_at(62); srq = 1'b0; idle = 1'b1;
      at_neg(85);  drained("R11 fires seen");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog at cycle %0d: actual 1 expected 0", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule